// File: doc/BRIEF.md
# Vectored-Interrupt Input Peripheral

This block sits on a simple processor bus as a peripheral. It latches a byte arriving on an external input whenever the input's valid strobe is high, and then raises a single interrupt request line. The processor answers with an acknowledge. While that acknowledge is seen, the block drives its own service-routine vector onto the shared read-data lines. The request then stays up until the processor reads the captured byte back through the bus, and that read clears it. A second bus location holds a byte that the processor writes, usually the processed result, and that byte is presented on an output port. A third location reports the request state and a sticky overrun flag.

The interrupt handshake is a four-state machine:
- IDLE: no request is pending.
- PENDING: the request line is high and the block waits for the acknowledge.
- VECTOR: the vector is being driven.
- WAIT_READ: the acknowledge has ended and the block waits for the data read.

The transitions are:
- CAPTURE: IDLE to PENDING on a strobe.
- ACK_SEEN: PENDING to VECTOR when the acknowledge is sampled high.
- ACK_DONE: VECTOR to WAIT_READ when the acknowledge is sampled low.
- SERVICED: PENDING, VECTOR or WAIT_READ to IDLE on a read of the data location, unless a strobe arrives in the same cycle.

The read-data bus is qualified by an output enable that models a tri-state driver. When the enable is low, the data lines are held at zero.

Top module: `vint_periph`

## Requirements
- R1: After synchronous active-high reset, `irq` is 0 and `result_q` is 0. A read of the data location (0x8000) returns 0, and a read of the status location (0x8002) returns 0.
- R2: When `ext_valid` is high at a clock edge, `ext_data` is stored in the input register. A later read of 0x8000 returns the stored byte.
- R3: A strobe taken in IDLE raises `irq` in the next cycle (transition CAPTURE).
- R4: If `irq_ack` is high at an edge while in PENDING, then from the next cycle `bus_oe` is 1 and `bus_rdata` equals parameter VECTOR (default 16). This holds until the edge at which `irq_ack` is sampled low. `irq_ack` sampled while `irq` is low has no effect.
- R5: A read of 0x8000 while `irq` is high returns the captured byte in that cycle and lowers `irq` in the next cycle, unless `ext_valid` is high in the same cycle.
- R6: A write to 0x8001 loads `bus_wdata` into `result_q` at that edge. Writes to other addresses leave `result_q` unchanged.
- R7: A strobe while `irq` is high overwrites the input register and sets a sticky overrun flag. Only reset clears the flag.
- R8: A read of 0x8002 returns bit 0 = overrun flag and bit 1 = `irq`. All other bits are 0.
- R9: `bus_oe` is 1 only in VECTOR or during a read of 0x8000 or 0x8002, and the vector takes priority over read data. When `bus_oe` is 0, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_data | input | 8 | External data byte |
| ext_valid | input | 1 | External data strobe |
| irq | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | Interrupt acknowledge, active high |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_rdata | output | 8 | Bus read data (zero when not enabled) |
| bus_oe | output | 1 | Read-data output enable |
| result_q | output | 8 | Processor-written result byte |

## Verification
The bench runs directed flows first:
- A clean capture, acknowledge and read sequence, which separates each state of the handshake.
- An acknowledge given with no request pending, which shows whether the acknowledge is wrongly honoured.
- A strobe arriving during a pending request, which exposes overrun and overwrite handling.
- A read and a strobe in the same cycle, which checks the precedence rule.

Seeded random traffic then mixes strobes, acknowledges, reads and writes to decoded and undecoded addresses. The results are compared every cycle against a bench model, which catches wrong priority between the vector and read data and stray writes.

// File: rtl/vint_pkg.sv
package vint_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PENDING   = 2'd1,
        ST_VECTOR    = 2'd2,
        ST_WAIT_READ = 2'd3
    } vint_state_t;
endpackage

// File: rtl/vint_fsm.sv
module vint_fsm
    import vint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap,
    input  logic ack,
    input  logic rd_data,
    output logic irq,
    output logic vec_phase
);
    vint_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rd_data && !cap && state_q != ST_IDLE) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (cap)  state_d = ST_PENDING;
                ST_PENDING:   if (ack)  state_d = ST_VECTOR;
                ST_VECTOR:    if (!ack) state_d = ST_WAIT_READ;
                ST_WAIT_READ: state_d = ST_WAIT_READ;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        irq       = 1'b0;
        vec_phase = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_PENDING:   irq = 1'b1;
            ST_VECTOR:    begin irq = 1'b1; vec_phase = 1'b1; end
            ST_WAIT_READ: irq = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/vint_regs.sv
module vint_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [DW-1:0] cap_data,
    input  logic          pend,
    input  logic          wr_out,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] in_q,
    output logic [DW-1:0] out_q,
    output logic          ovr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            out_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (cap)         in_q  <= cap_data;
            if (wr_out)      out_q <= wdata;
            if (cap && pend) ovr_q <= 1'b1;
        end
    end
endmodule

// File: rtl/vint_busdrv.sv
module vint_busdrv #(
    parameter int          DW     = 8,
    parameter logic [DW-1:0] VECTOR = 8'd16
) (
    input  logic          vec_phase,
    input  logic          rd_data,
    input  logic          rd_stat,
    input  logic [DW-1:0] in_q,
    input  logic          ovr,
    input  logic          irq,
    output logic          oe,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] stat_word;

    always_comb begin
        stat_word    = '0;
        stat_word[0] = ovr;
        stat_word[1] = irq;
    end

    always_comb begin
        oe    = 1'b0;
        rdata = '0;
        if (vec_phase) begin
            oe    = 1'b1;
            rdata = VECTOR;
        end else if (rd_data) begin
            oe    = 1'b1;
            rdata = in_q;
        end else if (rd_stat) begin
            oe    = 1'b1;
            rdata = stat_word;
        end
    end
endmodule

// File: rtl/vint_periph.sv
module vint_periph #(
    parameter int              DW        = 8,
    parameter int              AW        = 16,
    parameter logic [DW-1:0]   VECTOR    = 8'd16,
    parameter logic [AW-1:0]   DATA_ADDR = 16'h8000,
    parameter logic [AW-1:0]   RES_ADDR  = 16'h8001,
    parameter logic [AW-1:0]   STAT_ADDR = 16'h8002
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ext_data,
    input  logic          ext_valid,
    output logic          irq,
    input  logic          irq_ack,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    input  logic          bus_wr,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_oe,
    output logic [DW-1:0] result_q
);
    logic          rd_data, rd_stat, wr_out, vec_phase, ovr_q;
    logic [DW-1:0] in_q;

    assign rd_data = bus_rd && (bus_addr == DATA_ADDR);
    assign rd_stat = bus_rd && (bus_addr == STAT_ADDR);
    assign wr_out  = bus_wr && (bus_addr == RES_ADDR);

    vint_fsm u_fsm (
        .clk(clk), .rst(rst), .cap(ext_valid), .ack(irq_ack),
        .rd_data(rd_data), .irq(irq), .vec_phase(vec_phase)
    );

    vint_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .cap(ext_valid), .cap_data(ext_data),
        .pend(irq), .wr_out(wr_out), .wdata(bus_wdata),
        .in_q(in_q), .out_q(result_q), .ovr_q(ovr_q)
    );

    vint_busdrv #(.DW(DW), .VECTOR(VECTOR)) u_bus (
        .vec_phase(vec_phase), .rd_data(rd_data), .rd_stat(rd_stat),
        .in_q(in_q), .ovr(ovr_q), .irq(irq),
        .oe(bus_oe), .rdata(bus_rdata)
    );
endmodule

// File: rtl/vint_checker.sv
module vint_checker #(
    parameter int              DW        = 8,
    parameter int              AW        = 16,
    parameter logic [DW-1:0]   VECTOR    = 8'd16,
    parameter logic [AW-1:0]   DATA_ADDR = 16'h8000
) (
    input logic          clk,
    input logic          rst,
    input logic          ext_valid,
    input logic          irq,
    input logic          irq_ack,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_oe,
    input logic [DW-1:0] bus_rdata,
    input logic          ovr_q
);
    assert_irq_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ext_valid));

    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(bus_rd && bus_addr == DATA_ADDR));

    assert_vector_value_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !bus_rd) |-> (bus_rdata == VECTOR));

    assert_ack_idle_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq) |=> !(bus_oe && !bus_rd));

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q);

    assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_rdata == '0));
endmodule

bind vint_periph vint_checker #(
    .DW(DW), .AW(AW), .VECTOR(VECTOR), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .ext_valid(ext_valid), .irq(irq), .irq_ack(irq_ack),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_oe(bus_oe),
    .bus_rdata(bus_rdata), .ovr_q(ovr_q)
);

// File: tb/sim_vint_periph.sv
`timescale 1ns/1ps
module sim_vint_periph;
    localparam logic [15:0] A_DATA = 16'h8000;
    localparam logic [15:0] A_RES  = 16'h8001;
    localparam logic [15:0] A_STAT = 16'h8002;
    localparam logic [7:0]  VEC    = 8'd16;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  ext_data, bus_wdata, bus_rdata, result_q;
    logic        ext_valid, irq, irq_ack, bus_rd, bus_wr, bus_oe;
    logic [15:0] bus_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int         ms;
    logic [7:0] m_in, m_out;
    logic       m_ovr;

    always #10 clk = ~clk;

    vint_periph u0 (
        .clk(clk), .rst(rst), .ext_data(ext_data), .ext_valid(ext_valid),
        .irq(irq), .irq_ack(irq_ack), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
        .result_q(result_q)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_oe(input logic r, input logic [15:0] ad);
        return (ms == 2) || (r && (ad == A_DATA || ad == A_STAT));
    endfunction

    function automatic logic [7:0] exp_rd(input logic r, input logic [15:0] ad);
        if (ms == 2)                return VEC;
        if (r && ad == A_DATA)      return m_in;
        if (r && ad == A_STAT)      return {6'b0, ms != 0, m_ovr};
        return 8'h00;
    endfunction

    task automatic step(input logic v, input logic [7:0] d, input logic a,
                        input logic r, input logic w, input logic [15:0] ad,
                        input logic [7:0] wd);
        logic rdin;
        @(negedge clk);
        ext_valid = v; ext_data = d; irq_ack = a;
        bus_rd = r; bus_wr = w; bus_addr = ad; bus_wdata = wd;
        #1;
        chk("R3/R5 irq", {15'b0, irq}, {15'b0, ms != 0});
        chk("R6 result_q", {8'b0, result_q}, {8'b0, m_out});
        chk("R9 bus_oe", {15'b0, bus_oe}, {15'b0, exp_oe(r, ad)});
        chk("R2/R4/R8 bus_rdata", {8'b0, bus_rdata}, {8'b0, exp_rd(r, ad)});
        @(posedge clk);
        rdin = r && (ad == A_DATA);
        if (v && ms != 0) m_ovr = 1'b1;
        if (v) m_in = d;
        if (w && ad == A_RES) m_out = wd;
        if (rdin && !v && ms != 0) ms = 0;
        else case (ms)
            0: if (v)  ms = 1;
            1: if (a)  ms = 2;
            2: if (!a) ms = 3;
            default: ;
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; ext_valid = 0; ext_data = 0; irq_ack = 0;
        bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        ms = 0; m_in = 0; m_out = 0; m_ovr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state, including read-backs
        step(0, 0, 0, 1, 0, A_DATA, 0);
        step(0, 0, 0, 1, 0, A_STAT, 0);
        // R4 ack with nothing pending is ignored
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R2 R3 capture then request
        step(1, 8'hA5, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R4 vector phase over two ack cycles
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R5 read clears request; R6 write result
        step(0, 0, 0, 1, 1, A_DATA, 8'h11);
        step(0, 0, 0, 0, 1, A_RES, 8'h5A);
        step(0, 0, 0, 0, 1, 16'h1234, 8'hFF);
        // R7 overrun: second strobe while pending; R8 status
        step(1, 8'h01, 0, 0, 0, 0, 0);
        step(1, 8'h02, 0, 1, 0, A_STAT, 0);
        step(0, 0, 0, 1, 0, A_STAT, 0);
        // R5 read and strobe in the same cycle keep irq
        step(1, 8'h03, 0, 1, 0, A_DATA, 0);
        step(0, 0, 0, 1, 0, A_DATA, 0);
        step(0, 0, 0, 1, 0, A_STAT, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ad;
            case ($urandom % 4)
                0: ad = A_DATA;
                1: ad = A_RES;
                2: ad = A_STAT;
                default: ad = 16'($urandom);
            endcase
            step(($urandom % 6) == 0, 8'($urandom), ($urandom % 3) == 0,
                 ($urandom % 4) == 0, ($urandom % 5) == 0, ad, 8'($urandom));
        end
        step(0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule